// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a high-rate input signal by a programmable ratio N and emits one short pulse per output period toward a phase comparator. The input signal is the block's clock (`fin_clk`), so every count below is in input edges. In prescaled mode, a dual-modulus prescaler divides by 33 or 32. A 12-bit main counter (P) counts prescaler periods. A 5-bit swallow counter (A) decides how many of those periods use the longer modulus. The total ratio is N = 32·P + A. In direct mode the prescaler is skipped and one counter divides by the 17-bit value {P, A}, which is numerically the same 32·P + A without the P ≥ A rule.

Software writes P, A and the mode into staging registers through a byte-wide write port. Nothing changes until a transfer is requested. The transferred setting is held as pending and replaces the running one only at the end of the current output period, so no output period is ever a blend of two settings. A setting that cannot be divided raises `cfg_err` and silences the output.

The write port is a plain strobe with no handshake. Every write is accepted in the cycle `bus_we` is high, and there is no back-pressure. The output pulse is likewise a plain level with no ready input.

Top module: `pss_divider`

## Requirements
- R1: While `rst` is high and after it is released, `div_pulse` is 0 and `cfg_err` is 1 until a valid setting has been transferred.
- R2: Write map, with the write taking effect on the rising edge where `bus_we` is 1. Address 0 loads P[7:0] from `bus_wdata[7:0]`. Address 1 loads P[11:8] from `bus_wdata[3:0]`. Address 2 loads A from `bus_wdata[4:0]` and the mode from `bus_wdata[7]` (1 = prescaled, 0 = direct). Address 3 with `bus_wdata[0]` = 1 requests a transfer. Writes to addresses 0 to 2 alone change neither the output period nor `cfg_err`.
- R3: In prescaled mode with a valid setting, consecutive pulses are exactly 32·P + A input cycles apart; the first A prescaler periods of each output period last 33 cycles and the rest last 32.
- R4: In direct mode with a valid setting, consecutive pulses are exactly {P, A} = 32·P + A input cycles apart.
- R5: `div_pulse` is high for exactly one cycle per output period and is never high in two consecutive cycles.
- R6: A setting is invalid when, in prescaled mode, P = 0 or P < A, or when, in direct mode, {P, A} < 2. While an invalid setting is active, `cfg_err` is 1 and no pulse is produced.
- R7: A transfer made during a valid period takes effect only at the end of that period; the period in progress keeps its old length and the next one has the new length.
- R8: When the active setting is invalid, a transfer applies on the sampling edge itself, and the first pulse becomes visible N + 1 cycles after that edge.
- R9: A transfer sampled on the same edge as the end of a period applies at that very boundary; the following period already has the new length.
- R10: A second transfer before the boundary replaces the first; only the latest transferred setting is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fin_clk | input | 1 | Input signal being divided, used as the clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the staging registers |
| bus_addr | input | 2 | Register select for the write |
| bus_wdata | input | 8 | Write data |
| div_pulse | output | 1 | One-cycle pulse at the end of each output period |
| cfg_err | output | 1 | The active setting cannot be divided |

## Verification
The transfer strobe and the end of an output period can land on the same edge, and the block must then switch settings at that exact boundary rather than defer by a whole extra period. The bench measures the running period from observed pulses. It raises the transfer in precisely the cycle before the predicted terminal edge. It then requires the interval ending at that boundary to equal the old N, and the next interval to equal the new N. A deferred switch would show up as a second old-length interval.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int P_W    = 12;          // main counter width
  localparam int A_W    = 5;           // swallow counter width
  localparam int PRE_W  = A_W;         // prescaler base modulus is 2**PRE_W
  localparam int N_W    = P_W + A_W;   // direct-mode ratio width
  localparam int BUS_AW = 2;
  localparam int BUS_DW = 8;
  localparam int P_HI_W = P_W - BUS_DW;

  localparam logic [BUS_AW-1:0] ADDR_P_LO = 2'd0;
  localparam logic [BUS_AW-1:0] ADDR_P_HI = 2'd1;
  localparam logic [BUS_AW-1:0] ADDR_A_MD = 2'd2;
  localparam logic [BUS_AW-1:0] ADDR_XFER = 2'd3;
  localparam int MODE_BIT = BUS_DW - 1;

  typedef enum logic {
    MODE_DIRECT    = 1'b0,
    MODE_PRESCALED = 1'b1
  } div_mode_e;

  typedef struct packed {
    div_mode_e        mode;
    logic [P_W-1:0]   p;
    logic [A_W-1:0]   a;
  } div_cfg_t;

  function automatic logic cfg_bad(input div_cfg_t c);
    logic [P_W-1:0] a_ext;
    logic [N_W-1:0] n_dir;
    a_ext = {{(P_W-A_W){1'b0}}, c.a};
    n_dir = {c.p, c.a};
    if (c.mode == MODE_PRESCALED)
      return (c.p == '0) || (c.p < a_ext);
    else
      return n_dir < N_W'(2);
  endfunction
endpackage

// File: rtl/pss_cfg_stage.sv
module pss_cfg_stage
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              boundary,
  output div_cfg_t          active_cfg,
  output div_cfg_t          load_cfg,
  output logic              pend_valid,
  output logic              commit
);
  div_cfg_t staged_cfg, pend_cfg, new_cfg;
  logic     apply;
  logic     unused_wdata;

  assign unused_wdata = ^bus_wdata[MODE_BIT-1:A_W];

  assign commit  = bus_we && (bus_addr == ADDR_XFER) && bus_wdata[0];
  assign apply   = boundary && (commit || pend_valid);
  // a transfer on the boundary edge bypasses the pending slot
  assign new_cfg = commit ? staged_cfg : pend_cfg;
  assign load_cfg = apply ? new_cfg : active_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_cfg <= '{mode: MODE_DIRECT, p: '0, a: '0};
    end else if (bus_we) begin
      unique case (bus_addr)
        ADDR_P_LO: staged_cfg.p[BUS_DW-1:0] <= bus_wdata;
        ADDR_P_HI: staged_cfg.p[P_W-1:BUS_DW] <= bus_wdata[P_HI_W-1:0];
        ADDR_A_MD: begin
          staged_cfg.a    <= bus_wdata[A_W-1:0];
          staged_cfg.mode <= div_mode_e'(bus_wdata[MODE_BIT]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_cfg <= '{mode: MODE_DIRECT, p: '0, a: '0};
      pend_cfg   <= '{mode: MODE_DIRECT, p: '0, a: '0};
      pend_valid <= 1'b0;
    end else begin
      active_cfg <= load_cfg;
      if (apply) begin
        pend_valid <= 1'b0;
      end else if (commit) begin
        pend_cfg   <= staged_cfg;
        pend_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pss_prescaler.sv
module pss_prescaler
  import pss_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic long_next,
  output logic tick
);
  localparam int CW = PRE_W + 1;
  localparam logic [CW-1:0] LONG_LOAD  = {1'b1, {PRE_W{1'b0}}};
  localparam logic [CW-1:0] SHORT_LOAD = {1'b0, {PRE_W{1'b1}}};

  logic [CW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= SHORT_LOAD;
    else if (load || tick)
      cnt <= long_next ? LONG_LOAD : SHORT_LOAD;
    else
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pss_prog_counter.sv
module pss_prog_counter
  import pss_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [P_W-1:0] load_p,
  input  logic [A_W-1:0] load_a,
  input  logic           tick,
  output logic           terminal,
  output logic           long_next
);
  logic [P_W-1:0] p_rem;
  logic [A_W-1:0] a_rem;

  assign terminal  = tick && (p_rem == P_W'(1));
  // next prescaler period is long while swallow pulses remain
  assign long_next = load ? (load_a != '0) : (a_rem > A_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      p_rem <= '0;
      a_rem <= '0;
    end else if (load) begin
      p_rem <= load_p;
      a_rem <= load_a;
    end else if (tick) begin
      p_rem <= p_rem - 1'b1;
      if (a_rem != '0) a_rem <= a_rem - 1'b1;
    end
  end
endmodule

// File: rtl/pss_direct_counter.sv
module pss_direct_counter
  import pss_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [N_W-1:0] load_n,
  output logic           terminal
);
  logic [N_W-1:0] cnt;

  assign terminal = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_n - 1'b1;
    else
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pss_divider.sv
module pss_divider
  import pss_pkg::*;
(
  input  logic              fin_clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              div_pulse,
  output logic              cfg_err
);
  div_cfg_t active_cfg, load_cfg;
  logic     boundary, pend_valid, commit;
  logic     pre_tick, long_next, ps_term, dir_term, term, bad;

  assign bad      = cfg_bad(active_cfg);
  assign term     = (active_cfg.mode == MODE_PRESCALED) ? ps_term : dir_term;
  assign boundary = term || bad;
  assign cfg_err  = bad;

  pss_cfg_stage u_stage (
    .clk        (fin_clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .boundary   (boundary),
    .active_cfg (active_cfg),
    .load_cfg   (load_cfg),
    .pend_valid (pend_valid),
    .commit     (commit)
  );

  pss_prescaler u_pre (
    .clk       (fin_clk),
    .rst       (rst),
    .load      (boundary),
    .long_next (long_next),
    .tick      (pre_tick)
  );

  pss_prog_counter u_prog (
    .clk       (fin_clk),
    .rst       (rst),
    .load      (boundary),
    .load_p    (load_cfg.p),
    .load_a    (load_cfg.a),
    .tick      (pre_tick),
    .terminal  (ps_term),
    .long_next (long_next)
  );

  pss_direct_counter u_dir (
    .clk      (fin_clk),
    .rst      (rst),
    .load     (boundary),
    .load_n   ({load_cfg.p, load_cfg.a}),
    .terminal (dir_term)
  );

  always_ff @(posedge fin_clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= term && !bad;
  end
endmodule

// File: rtl/pss_divider_chk.sv
module pss_divider_chk (
  input logic fin_clk,
  input logic rst,
  input logic div_pulse,
  input logic cfg_err,
  input logic pend_valid,
  input logic commit
);
  // R1: first cycle after reset shows no valid setting and no pulse
  assert_reset_state_R1: assert property (@(posedge fin_clk) disable iff (rst)
    $past(rst) |-> (cfg_err && !div_pulse));

  // R5: pulse never lasts two cycles
  assert_pulse_width_R5: assert property (@(posedge fin_clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R6: an invalid setting that persists produces no pulse
  assert_silent_invalid_R6: assert property (@(posedge fin_clk) disable iff (rst)
    (cfg_err && $past(cfg_err)) |-> !div_pulse);

  // R2: without a transfer in flight, staging writes leave the error flag alone
  assert_no_xfer_no_change_R2: assert property (@(posedge fin_clk) disable iff (rst)
    (!pend_valid && !commit) |=> $stable(cfg_err));
endmodule

bind pss_divider pss_divider_chk u_chk (
  .fin_clk    (fin_clk),
  .rst        (rst),
  .div_pulse  (div_pulse),
  .cfg_err    (cfg_err),
  .pend_valid (pend_valid),
  .commit     (commit)
);

// File: tb/test_pss_divider.sv
module test_pss_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // mode, P, A, expected N
  localparam int VEC [NVEC][4] = '{
    '{1, 1, 0, 32}, '{1, 1, 1, 33}, '{1, 3, 2, 98}, '{1, 5, 5, 165},
    '{1, 10, 0, 320}, '{1, 31, 31, 1023}, '{1, 100, 7, 3207},
    '{0, 0, 5, 5}, '{0, 0, 2, 2}, '{0, 1, 3, 35}, '{0, 2, 0, 64}, '{0, 0, 31, 31}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       div_pulse, cfg_err;

  int checks = 0, failures = 0;
  int cyc = 0, pulse_count = 0, last_pulse_cyc = 0, last_interval = 0;
  int width_err = 0, last_commit_cyc = 0;
  logic prev_pulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pss_divider i_pss_divider (
    .fin_clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (div_pulse === 1'b1) begin
      last_interval  = cyc - last_pulse_cyc;
      last_pulse_cyc = cyc;
      pulse_count    = pulse_count + 1;
      if (prev_pulse) width_err = width_err + 1;
    end
    prev_pulse = (div_pulse === 1'b1);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 2'd3) last_commit_cyc = cyc;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic stage(input int mode, input int p, input int a);
    bus_write(2'd0, 8'(p));
    bus_write(2'd1, 8'(p >> 8));
    bus_write(2'd2, {mode[0], 2'b00, 5'(a)});
  endtask

  task automatic transfer();
    bus_write(2'd3, 8'h01);
  endtask

  task automatic wait_pulses(input int n);
    int target;
    target = pulse_count + n;
    while (pulse_count < target) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int pc, q, target;
    repeat (5) @(negedge clk);
    check(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
    check(cfg_err == 1'b1, "R1 err in reset", int'(cfg_err), 1);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    check(pulse_count == 0, "R1 no pulse after reset", pulse_count, 0);
    check(cfg_err == 1'b1, "R1 err after reset", int'(cfg_err), 1);

    // table of settings: R3 prescaled, R4 direct
    for (int i = 0; i < NVEC; i++) begin
      stage(VEC[i][0], VEC[i][1], VEC[i][2]);
      transfer();
      wait_pulses(2);
      check(last_interval == VEC[i][3], VEC[i][0] == 1 ? "R3 period" : "R4 period",
            last_interval, VEC[i][3]);
      check(cfg_err == 1'b0, VEC[i][0] == 1 ? "R3 err clear" : "R4 err clear",
            int'(cfg_err), 0);
    end

    // running setting: prescaled P=2 A=1 -> 65
    stage(1, 2, 1); transfer(); wait_pulses(2);
    check(last_interval == 65, "R3 period 65", last_interval, 65);

    // R2: staging an invalid setting without transfer changes nothing
    stage(1, 1, 9);
    wait_pulses(3);
    check(last_interval == 65, "R2 period kept", last_interval, 65);
    check(cfg_err == 1'b0, "R2 err kept", int'(cfg_err), 0);

    // R7: mid-period transfer to direct 40
    wait_pulses(1);
    repeat (10) @(negedge clk);
    stage(0, 1, 8); transfer();
    wait_pulses(1);
    check(last_interval == 65, "R7 old period completes", last_interval, 65);
    wait_pulses(1);
    check(last_interval == 40, "R7 new period", last_interval, 40);

    // R10: two transfers before the boundary, latest (direct 50) wins
    wait_pulses(1);
    stage(1, 2, 0); transfer();
    stage(0, 1, 18); transfer();
    wait_pulses(1);
    check(last_interval == 40, "R10 old period completes", last_interval, 40);
    wait_pulses(1);
    check(last_interval == 50, "R10 latest applied", last_interval, 50);

    // R9: transfer lands on the terminal edge of a 50-cycle period
    stage(1, 1, 0);
    wait_pulses(1);
    q = last_pulse_cyc;
    target = q + 50 - 2;
    while (cyc != target) @(negedge clk);
    bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h01;
    @(negedge clk);
    bus_we = 1'b0;
    wait_pulses(1);
    check(last_interval == 50, "R9 boundary period", last_interval, 50);
    wait_pulses(1);
    check(last_interval == 32, "R9 switched at boundary", last_interval, 32);

    // R6: prescaled P=2 A=5 is invalid
    stage(1, 2, 5); transfer();
    wait_pulses(1);
    @(negedge clk);
    check(cfg_err == 1'b1, "R6 prescaled P<A flagged", int'(cfg_err), 1);
    pc = pulse_count;
    repeat (300) @(negedge clk);
    check(pulse_count == pc, "R6 silent while invalid", pulse_count - pc, 0);

    // R6: direct ratio 1 is invalid
    stage(0, 0, 1); transfer();
    repeat (2) @(negedge clk);
    check(cfg_err == 1'b1, "R6 direct ratio 1 flagged", int'(cfg_err), 1);
    pc = pulse_count;
    repeat (100) @(negedge clk);
    check(pulse_count == pc, "R6 direct silent", pulse_count - pc, 0);

    // R8: recovery from invalid, first pulse N+1 cycles after the edge
    stage(1, 1, 1); transfer();
    wait_pulses(1);
    check(last_pulse_cyc - last_commit_cyc == 35, "R8 first pulse latency",
          last_pulse_cyc - last_commit_cyc, 35);
    wait_pulses(1);
    check(last_interval == 33, "R8 period after recovery", last_interval, 33);

    check(width_err == 0, "R5 single-cycle pulses", width_err, 0);
    check(pulse_count > 40, "R5 pulses observed", pulse_count, 41);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule